// File: doc/BRIEF.md
# Track Trigger Term Generator

This block turns the reconstructed forward tracks of one beam crossing into a 16-bit vector of trigger terms. Tracks arrive one per clock. Each carries a spectrometer index, an unsigned fixed-point momentum fraction and an unsigned fixed-point momentum transfer. A separate input carries the 4-bit status word that the coincidence encoder produced for each of the nine spectrometers. A track takes part in the trigger only when the status word of its spectrometer reports a clean in-time coincidence.

Each qualified track is compared against three threshold ports: an upper fraction cut, a lower fraction cut and a momentum-transfer cut. The results are OR-accumulated across the event. Elastic terms look for qualified high-fraction tracks in a proton-side arm and in the diagonally opposite antiproton-side arm. The track flagged as last closes the event. One cycle later the block publishes the term vector together with a one-cycle done strobe.

With the intended scaling, a fraction of 1.0 is 1024 and a transfer of 1 GeV² is 16. The thresholds are then 1014, 922 and 16. The block does not reconstruct tracks.

Top module: `trkterm_gen`

## Requirements
- R1: A track is qualified only if `trkSpec` is below 9 and the status word of that spectrometer equals 1. Spectrometer s uses bits `[4*s+3:4*s]` of `specStatus`. Unqualified tracks contribute to no term.
- R2: Term bit 0 is set when any qualified track has fraction strictly greater than `thrXiHi`.
- R3: Term bit 1 is set when any qualified track has fraction strictly greater than `thrXiLo` and not greater than `thrXiHi`.
- R4: Term bit 2 is set when any qualified track has fraction strictly greater than `thrXiLo` and transfer strictly greater than `thrT`.
- R5: Term bit 3 is set when any qualified track has fraction strictly greater than `thrXiLo`, whatever its transfer.
- R6: Term bit 4 is set when the event holds qualified tracks with fraction above `thrXiHi` in a diagonal pair of arms. Spectrometers 0–3 are the proton arms and 4–7 the antiproton arms. The pairs are 0–5, 1–4, 2–7 and 3–6. Spectrometer 8 has no partner.
- R7: Term bit 5 is set under the rule of R6 when both tracks of the pair also have transfer strictly greater than `thrT`.
- R8: Only the first 7 tracks of an event are evaluated. Later tracks have no effect on the terms, but a later track flagged last still closes the event.
- R9: `termDone` is high for exactly the one cycle after the cycle in which a track with `trkLast` is presented. `termVec` changes only on that edge and holds its value afterwards.
- R10: Term bits 6 to 15 always read zero.
- R11: After reset, `termVec` is zero and `termDone` is low.
- R12: Each event starts from an empty accumulation. Terms of a previous event do not carry over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trkValid | input | 1 | A track is presented this cycle |
| trkLast | input | 1 | The presented track is the last of the event |
| trkSpec | input | 4 | Spectrometer index of the track |
| trkXi | input | 10 | Momentum fraction, unsigned fixed point |
| trkT | input | 8 | Momentum transfer, unsigned fixed point |
| specStatus | input | 36 | Nine 4-bit spectrometer status words |
| thrXiHi | input | 10 | Upper fraction threshold |
| thrXiLo | input | 10 | Lower fraction threshold |
| thrT | input | 8 | Momentum-transfer threshold |
| termVec | output | 16 | Published trigger terms |
| termDone | output | 1 | One-cycle strobe marking a new `termVec` |

## Verification
The bench drives fractions exactly at the thresholds and one step above them. A design that uses `>=` would fire the high-fraction term at 1014, or the band terms at 922. It pairs high-fraction tracks in diagonal arms and in same-side-index arms, so that a wrong partner mapping either misses or falsely fires the elastic terms. The bench also sets halo-flagged status codes and out-of-range spectrometer indices that must be ignored. It sends events longer than seven tracks in which only the eighth track would fire, and follows a firing event with an empty one to catch an accumulator that is never cleared.

// File: rtl/trkterm_pkg.sv
package trkterm_pkg;
  localparam int NUM_SPEC   = 9;
  localparam int SPEC_IDX_W = 4;
  localparam int STAT_W     = 4;
  localparam int XI_W       = 10;
  localparam int T_W        = 8;
  localparam int TERM_W     = 16;
  localparam int MAX_TRACKS = 7;
  localparam int NUM_ARM    = 4;
  localparam int P_BASE     = 0;
  localparam int A_BASE     = 4;
  localparam logic [STAT_W-1:0] STAT_CLEAN = 4'd1;

  localparam int T_XI_HI   = 0;
  localparam int T_XI_MID  = 1;
  localparam int T_XI_T    = 2;
  localparam int T_XI_LO   = 3;
  localparam int T_ELAS    = 4;
  localparam int T_ELAS_T  = 5;
  localparam int NUM_USED  = 6;

  typedef struct packed {
    logic accEn;
    logic publish;
  } ctlStrobe_t;
endpackage

// File: rtl/trkterm_ctrl.sv
module trkterm_ctrl
  import trkterm_pkg::*;
#(
  parameter int MAX_TRK = MAX_TRACKS
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trkValid,
  input  logic       trkLast,
  output ctlStrobe_t strobe
);
  localparam int CNT_W = $clog2(MAX_TRK + 1);

  logic [CNT_W-1:0] trkCnt;
  logic             room;

  assign room = (trkCnt < CNT_W'(MAX_TRK));

  always_comb begin
    strobe.accEn   = trkValid && room;
    strobe.publish = trkValid && trkLast;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trkCnt <= '0;
    end else if (strobe.publish) begin
      trkCnt <= '0;
    end else if (strobe.accEn) begin
      trkCnt <= trkCnt + 1'b1;
    end
  end
endmodule

// File: rtl/trkterm_dp.sv
module trkterm_dp
  import trkterm_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  ctlStrobe_t                   strobe,
  input  logic [SPEC_IDX_W-1:0]        trkSpec,
  input  logic [XI_W-1:0]              trkXi,
  input  logic [T_W-1:0]               trkT,
  input  logic [NUM_SPEC*STAT_W-1:0]   specStatus,
  input  logic [XI_W-1:0]              thrXiHi,
  input  logic [XI_W-1:0]              thrXiLo,
  input  logic [T_W-1:0]               thrT,
  output logic [TERM_W-1:0]            termVec,
  output logic                         termDone
);
  logic [STAT_W-1:0]   statArr [NUM_SPEC];
  logic                qual, hiHit, loHit, tHit;
  logic [NUM_USED-1:0] trkTerms, accTerms, nextTerms;
  logic [NUM_ARM-1:0]  curP, curA, curPT, curAT;
  logic [NUM_ARM-1:0]  pMask, aMask, pTMask, aTMask;
  logic [NUM_ARM-1:0]  nextP, nextA, nextPT, nextAT;
  logic [NUM_ARM-1:0]  swapA, swapAT;
  logic                elas, elasT;

  genvar gs;
  generate
    for (gs = 0; gs < NUM_SPEC; gs++) begin : g_unpack
      assign statArr[gs] = specStatus[gs*STAT_W +: STAT_W];
    end
  endgenerate

  always_comb begin
    qual = 1'b0;
    for (int s = 0; s < NUM_SPEC; s++) begin
      if (trkSpec == SPEC_IDX_W'(s) && statArr[s] == STAT_CLEAN) qual = 1'b1;
    end
  end

  assign hiHit = trkXi > thrXiHi;
  assign loHit = trkXi > thrXiLo;
  assign tHit  = trkT > thrT;

  genvar ga;
  generate
    for (ga = 0; ga < NUM_ARM; ga++) begin : g_arm
      assign curP[ga]  = qual && hiHit && (trkSpec == SPEC_IDX_W'(P_BASE + ga));
      assign curA[ga]  = qual && hiHit && (trkSpec == SPEC_IDX_W'(A_BASE + ga));
      assign curPT[ga] = curP[ga] && tHit;
      assign curAT[ga] = curA[ga] && tHit;
      assign swapA[ga]  = nextA[ga ^ 1];
      assign swapAT[ga] = nextAT[ga ^ 1];
    end
  endgenerate

  always_comb begin
    trkTerms = '0;
    trkTerms[T_XI_HI]  = qual && hiHit;
    trkTerms[T_XI_MID] = qual && loHit && !hiHit;
    trkTerms[T_XI_T]   = qual && loHit && tHit;
    trkTerms[T_XI_LO]  = qual && loHit;

    nextP  = pMask;
    nextA  = aMask;
    nextPT = pTMask;
    nextAT = aTMask;
    nextTerms = accTerms;
    if (strobe.accEn) begin
      nextP  = pMask | curP;
      nextA  = aMask | curA;
      nextPT = pTMask | curPT;
      nextAT = aTMask | curAT;
      nextTerms = accTerms | trkTerms;
    end
  end

  assign elas  = |(nextP & swapA);
  assign elasT = |(nextPT & swapAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accTerms <= '0;
      pMask    <= '0;
      aMask    <= '0;
      pTMask   <= '0;
      aTMask   <= '0;
      termVec  <= '0;
      termDone <= 1'b0;
    end else if (strobe.publish) begin
      termVec               <= '0;
      termVec[T_XI_LO:0]    <= nextTerms[T_XI_LO:0];
      termVec[T_ELAS]       <= elas;
      termVec[T_ELAS_T]     <= elasT;
      termDone              <= 1'b1;
      accTerms <= '0;
      pMask    <= '0;
      aMask    <= '0;
      pTMask   <= '0;
      aTMask   <= '0;
    end else begin
      termDone <= 1'b0;
      accTerms <= nextTerms;
      pMask    <= nextP;
      aMask    <= nextA;
      pTMask   <= nextPT;
      aTMask   <= nextAT;
    end
  end
endmodule

// File: rtl/trkterm_gen.sv
module trkterm_gen
  import trkterm_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       trkValid,
  input  logic                       trkLast,
  input  logic [SPEC_IDX_W-1:0]      trkSpec,
  input  logic [XI_W-1:0]            trkXi,
  input  logic [T_W-1:0]             trkT,
  input  logic [NUM_SPEC*STAT_W-1:0] specStatus,
  input  logic [XI_W-1:0]            thrXiHi,
  input  logic [XI_W-1:0]            thrXiLo,
  input  logic [T_W-1:0]             thrT,
  output logic [TERM_W-1:0]          termVec,
  output logic                       termDone
);
  ctlStrobe_t strobe;

  trkterm_ctrl #(.MAX_TRK(MAX_TRACKS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .trkValid (trkValid),
    .trkLast  (trkLast),
    .strobe   (strobe)
  );

  trkterm_dp u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .trkSpec    (trkSpec),
    .trkXi      (trkXi),
    .trkT       (trkT),
    .specStatus (specStatus),
    .thrXiHi    (thrXiHi),
    .thrXiLo    (thrXiLo),
    .thrT       (thrT),
    .termVec    (termVec),
    .termDone   (termDone)
  );
endmodule

// File: rtl/trkterm_chk.sv
module trkterm_chk
  import trkterm_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       trkValid,
  input logic                       trkLast,
  input logic [SPEC_IDX_W-1:0]      trkSpec,
  input logic [XI_W-1:0]            trkXi,
  input logic [T_W-1:0]             trkT,
  input logic [NUM_SPEC*STAT_W-1:0] specStatus,
  input logic [XI_W-1:0]            thrXiHi,
  input logic [XI_W-1:0]            thrXiLo,
  input logic [T_W-1:0]             thrT,
  input logic [TERM_W-1:0]          termVec,
  input logic                       termDone
);
  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    termDone |-> $past(trkValid && trkLast));

  p_done_follows_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trkValid && trkLast) |=> termDone);

  p_vec_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !termDone |-> $stable(termVec));

  p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    termVec[TERM_W-1:NUM_USED] == '0);

  p_xit_implies_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    termVec[T_XI_T] |-> termVec[T_XI_LO]);

  p_elast_implies_elas_r7: assert property (@(posedge clk) disable iff (!rst_n)
    termVec[T_ELAS_T] |-> termVec[T_ELAS]);

  p_elas_implies_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    termVec[T_ELAS] |-> termVec[T_XI_HI]);
endmodule

bind trkterm_gen trkterm_chk u_chk (.*);

// File: tb/trkterm_gen_tb.sv
module trkterm_gen_tb;
  localparam int HI = 1014;
  localparam int LO = 922;
  localparam int TT = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trkValid = 1'b0, trkLast = 1'b0;
  logic [3:0]  trkSpec = '0;
  logic [9:0]  trkXi = '0;
  logic [7:0]  trkT = '0;
  logic [35:0] specStatus;
  logic [15:0] termVec;
  logic        termDone;

  int checks = 0, errors = 0;
  int tSpec [16];
  int tXi [16];
  int tT [16];
  logic [3:0] stat [9];

  always #2 clk = ~clk;

  always_comb
    for (int s = 0; s < 9; s++) specStatus[s*4 +: 4] = stat[s];

  trkterm_gen u_dut (
    .clk(clk), .rst_n(rst_n), .trkValid(trkValid), .trkLast(trkLast),
    .trkSpec(trkSpec), .trkXi(trkXi), .trkT(trkT), .specStatus(specStatus),
    .thrXiHi(10'(HI)), .thrXiLo(10'(LO)), .thrT(8'(TT)),
    .termVec(termVec), .termDone(termDone)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expTerms(int n);
    logic [15:0] e = '0;
    logic [3:0] pH = '0, aH = '0, pT = '0, aT = '0;
    for (int i = 0; i < n && i < 7; i++) begin
      int s = tSpec[i];
      bit hi, lo, th;
      if (s >= 9) continue;
      if (stat[s] != 4'd1) continue;
      hi = tXi[i] > HI; lo = tXi[i] > LO; th = tT[i] > TT;
      if (hi) e[0] = 1'b1;
      if (lo && !hi) e[1] = 1'b1;
      if (lo && th) e[2] = 1'b1;
      if (lo) e[3] = 1'b1;
      if (hi && s < 4) begin pH[s] = 1'b1; if (th) pT[s] = 1'b1; end
      if (hi && s >= 4 && s < 8) begin aH[s-4] = 1'b1; if (th) aT[s-4] = 1'b1; end
    end
    for (int k = 0; k < 4; k++) begin
      if (pH[k] && aH[k^1]) e[4] = 1'b1;
      if (pT[k] && aT[k^1]) e[5] = 1'b1;
    end
    return e;
  endfunction

  task automatic runEvent(int n, string req, logic [15:0] lit, bit useLit);
    logic [15:0] e;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      trkValid = 1'b1; trkLast = (i == n - 1);
      trkSpec = 4'(tSpec[i]); trkXi = 10'(tXi[i]); trkT = 8'(tT[i]);
    end
    @(posedge clk); #1;
    e = expTerms(n);
    check({req, " done"}, {15'd0, termDone}, 16'd1);
    check(req, termVec, e);
    if (useLit) check({req, " literal"}, termVec, lit);
    @(negedge clk); trkValid = 1'b0; trkLast = 1'b0;
    @(posedge clk); #1;
    check("R9 done single cycle", {15'd0, termDone}, 16'd0);
    check("R9 vec held", termVec, e);
  endtask

  task automatic setTrk(int i, int s, int x, int t);
    tSpec[i] = s; tXi[i] = x; tT[i] = t;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int s = 0; s < 9; s++) stat[s] = 4'd1;
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset vec", termVec, 16'h0000);
    check("R11 reset done", {15'd0, termDone}, 16'd0);
    @(negedge clk); rst_n = 1'b1;

    setTrk(0, 0, 1014, 5);  runEvent(1, "R3 xi at upper threshold", 16'h000A, 1);
    setTrk(0, 0, 1015, 5);  runEvent(1, "R2 xi above upper", 16'h0009, 1);
    setTrk(0, 2, 922, 99);  runEvent(1, "R5 xi at lower threshold", 16'h0000, 1);
    setTrk(0, 2, 923, 16);  runEvent(1, "R5 xi above lower, t at cut", 16'h000A, 1);
    setTrk(0, 2, 950, 17);  runEvent(1, "R4 t above cut", 16'h000E, 1);
    stat[1] = 4'd3;
    setTrk(0, 1, 1020, 40); runEvent(1, "R1 halo status ignored", 16'h0000, 1);
    stat[1] = 4'd2;
    setTrk(0, 1, 1020, 40); setTrk(1, 12, 1020, 40);
    runEvent(2, "R1 halo and bad index ignored", 16'h0000, 1);
    stat[1] = 4'd1;
    setTrk(0, 0, 1020, 20); setTrk(1, 5, 1016, 30);
    runEvent(2, "R6 R7 diagonal pair 0-5", 16'h003D, 1);
    setTrk(0, 3, 1020, 20); setTrk(1, 6, 1016, 10);
    runEvent(2, "R6 pair 3-6, R7 t fails", 16'h001D, 1);
    setTrk(0, 0, 1020, 20); setTrk(1, 4, 1016, 30);
    runEvent(2, "R6 non-diagonal 0-4", 16'h000D, 1);
    setTrk(0, 8, 1020, 20); setTrk(1, 2, 1016, 30);
    runEvent(2, "R6 spec 8 has no partner", 16'h000D, 1);
    for (int i = 0; i < 7; i++) setTrk(i, 9, 1020, 30);
    setTrk(7, 0, 1020, 30);
    runEvent(8, "R8 eighth track ignored", 16'h0000, 1);
    setTrk(0, 1, 1020, 30); setTrk(1, 4, 1020, 30);
    runEvent(2, "R12 firing event", 16'h003D, 1);
    setTrk(0, 1, 100, 0);
    runEvent(1, "R12 next event starts empty", 16'h0000, 1);

    for (int ev = 0; ev < 300; ev++) begin
      int n = 1 + int'($urandom % 9);
      for (int s = 0; s < 9; s++) stat[s] = ($urandom % 4 == 0) ? 4'($urandom % 4) : 4'd1;
      for (int i = 0; i < n; i++) begin
        int r = int'($urandom % 6);
        int x = (r == 0) ? 1014 : (r == 1) ? 922 : (r == 2) ? 1015 + int'($urandom % 9)
              : (r == 3) ? 923 + int'($urandom % 91) : int'($urandom % 1024);
        setTrk(i, int'($urandom % 11), x, int'($urandom % 40));
      end
      runEvent(n, "R2 R3 R4 R5 R6 R7 R8 random", 16'h0, 0);
      checks++;
      if (termVec[15:6] != 0) begin
        errors++;
        $display("FAIL R10 upper bits actual=%h expected=000", termVec[15:6]);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule